// File: doc/BRIEF.md
# Accumulator Datapath with Constant Operand Injection

This block is an 8-bit arithmetic datapath built around two accumulators, A0 and A1, and an adder-based ALU. A 3-bit state input selects one of eight stored instruction words on every clock. Each word sets five things: the ALU function, which accumulator drives operand A, whether an external parallel input replaces that operand, which accumulator drives operand B, and where the result is written. A further bit in the word makes the ALU take its carry-in from a registered carry flag. With that option, a low-byte add or subtract into A0 followed by a decrement of A1 performs 16-bit arithmetic in two cycles.

Operand A is built in two stages. The first stage picks A0 or A1. The second stage can replace that choice with the parallel input, but only when a static enable pin is high and the current instruction also requests it. The parallel output is taken from the first stage, so it always shows an accumulator and never the injected constant. The block has no streaming interface and no back-pressure. The parallel input and the state input are sampled at every rising edge, and each edge executes exactly one instruction. The instruction store is written through a configuration port, and only while reset is asserted.

Top module: `dp_accum8`

## Requirements
- R1: Asserting rst_n low clears A0, A1 and the registered carry at once. The contents of the instruction store are kept.
- R2: The store accepts a configuration write (cfg_we high at a rising edge) only while rst_n is low. A write made while rst_n is high has no effect.
- R3: The instruction word is {fn[7:6], a_hi[5], use_pin[4], b_hi[3], wb[2:1], chain[0]}. Operand A is A1 when a_hi=1 and A0 otherwise. It is replaced by pin only when both pin_en and use_pin are 1. Operand B is A1 when b_hi=1 and A0 otherwise.
- R4: pout shows the accumulator chosen by a_hi of the current instruction. It never shows pin, even while pin feeds the ALU.
- R5: The fn field selects the operation, with 8-bit wrap: 0 = PASS (A), 1 = ADD (A+B+cin), 2 = SUB (A+~B+cin), 3 = DEC (A+0xFF+cin). The default cin is 0 for ADD and DEC and 1 for SUB.
- R6: The wb field selects the write-back: 0 = none, 1 = A0, 2 = A1, 3 = both. The result appears on the accumulators after the rising edge that executes the instruction.
- R7: flag_carry is the registered carry-out (bit 8 of the 9-bit sum). For ADD it is 1 on unsigned overflow. For SUB it is 1 when no borrow occurs. ADD, SUB and DEC update it; PASS leaves it unchanged.
- R8: When chain=1, cin is the current flag_carry value in place of the default. When chain=0, flag_carry has no effect on the result.
- R9: ADD of a two's-complement constant into A0, followed by a chained DEC on A1, gives the correct 16-bit difference {A1,A0}.
- R10: zero_a0, zero_a1 and eq_a01 show, combinationally, whether A0 is zero, whether A1 is zero and whether A0 equals A1.
- R11: The state input may select a different instruction on every cycle, and each edge executes the instruction selected at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also gates store writes |
| cfg_we | input | 1 | Instruction store write strobe |
| cfg_addr | input | 3 | Instruction store slot to write |
| cfg_word | input | 8 | Instruction word to store |
| pin_en | input | 1 | Static enable for parallel input injection |
| state | input | 3 | Instruction select, sampled every cycle |
| pin | input | 8 | Parallel input constant |
| pout | output | 8 | Parallel output (first-stage operand A) |
| flag_carry | output | 1 | Registered carry |
| zero_a0 | output | 1 | A0 equals zero |
| zero_a1 | output | 1 | A1 equals zero |
| eq_a01 | output | 1 | A0 equals A1 |

## Verification
A wrong accumulator value is visible on pout in the same cycle, as soon as the state input selects an instruction whose a_hi bit points at that accumulator. It is also visible on the zero and equality flags, so the effect of a bad write-back shows one edge after the faulty instruction. A corrupted registered carry appears on flag_carry at once. It also alters the result of the next chained instruction, so the high byte of a 16-bit sequence exposes it one cycle later. A store slot corrupted or overwritten outside reset shows up on the first cycle that selects that slot, either as the wrong accumulator on pout or as an unexpected write.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [1:0] {
    FN_PASS = 2'd0,
    FN_ADD  = 2'd1,
    FN_SUB  = 2'd2,
    FN_DEC  = 2'd3
  } fn_e;

  typedef enum logic [1:0] {
    WB_NONE = 2'd0,
    WB_A0   = 2'd1,
    WB_A1   = 2'd2,
    WB_BOTH = 2'd3
  } wb_e;

  // packed: first field is the most significant
  typedef struct packed {
    fn_e  fn;       // [7:6]
    logic a_hi;     // [5]  first-stage operand A select
    logic use_pin;  // [4]  dynamic request for parallel input
    logic b_hi;     // [3]  operand B select
    wb_e  wb;       // [2:1]
    logic chain;    // [0]  carry-in from registered carry
  } instr_t;

  localparam int unsigned INSTR_W = $bits(instr_t);

endpackage

// File: rtl/dp_istore.sv
module dp_istore
  import dp_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  instr_t        wr_data,
  input  logic [AW-1:0] rd_addr,
  output instr_t        rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  instr_t slot_q [DEPTH];

  // writes are honoured only while the datapath is held in reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && !rst_n && (wr_addr == AW'(g)))
        slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_addr];

endmodule

// File: rtl/dp_opmux.sv
module dp_opmux #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a0,
  input  logic [DW-1:0] a1,
  input  logic [DW-1:0] pin,
  input  logic          pin_en,
  input  logic          a_hi,
  input  logic          use_pin,
  input  logic          b_hi,
  output logic [DW-1:0] tap,
  output logic [DW-1:0] opa,
  output logic [DW-1:0] opb
);
  logic inject;

  // stage one: accumulator choice, also the parallel-output tap
  assign tap    = a_hi ? a1 : a0;
  // stage two: static enable AND per-instruction request
  assign inject = pin_en & use_pin;
  assign opa    = inject ? pin : tap;
  assign opb    = b_hi ? a1 : a0;

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  fn_e           fn,
  input  logic          chain,
  input  logic          creg,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          c_upd
);
  logic [DW-1:0] addend;
  logic          cin;
  logic [DW:0]   sum;

  always_comb begin
    addend = '0;
    cin    = 1'b0;
    c_upd  = 1'b1;
    unique case (fn)
      FN_PASS: begin
        addend = '0;
        cin    = 1'b0;
        c_upd  = 1'b0;
      end
      FN_ADD: begin
        addend = opb;
        cin    = chain ? creg : 1'b0;
      end
      FN_SUB: begin
        addend = ~opb;
        cin    = chain ? creg : 1'b1;
      end
      FN_DEC: begin
        addend = '1;
        cin    = chain ? creg : 1'b0;
      end
      default: begin
        addend = '0;
        cin    = 1'b0;
        c_upd  = 1'b0;
      end
    endcase
  end

  assign sum  = {1'b0, opa} + {1'b0, addend} + {{DW{1'b0}}, cin};
  assign res  = sum[DW-1:0];
  assign cout = sum[DW];

endmodule

// File: rtl/dp_accum8.sv
module dp_accum8
  import dp_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [INSTR_W-1:0] cfg_word,
  input  logic               pin_en,
  input  logic [AW-1:0]      state,
  input  logic [DW-1:0]      pin,
  output logic [DW-1:0]      pout,
  output logic               flag_carry,
  output logic               zero_a0,
  output logic               zero_a1,
  output logic               eq_a01
);
  instr_t        ins;
  logic [DW-1:0] a0_q, a1_q;
  logic          carry_q;
  logic [DW-1:0] tap, opa, opb, res;
  logic          cout, c_upd;
  logic          wr_a0, wr_a1;

  dp_istore #(.AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (instr_t'(cfg_word)),
    .rd_addr (state),
    .rd_data (ins)
  );

  dp_opmux #(.DW(DW)) u_mux (
    .a0      (a0_q),
    .a1      (a1_q),
    .pin     (pin),
    .pin_en  (pin_en),
    .a_hi    (ins.a_hi),
    .use_pin (ins.use_pin),
    .b_hi    (ins.b_hi),
    .tap     (tap),
    .opa     (opa),
    .opb     (opb)
  );

  dp_alu #(.DW(DW)) u_alu (
    .fn    (ins.fn),
    .chain (ins.chain),
    .creg  (carry_q),
    .opa   (opa),
    .opb   (opb),
    .res   (res),
    .cout  (cout),
    .c_upd (c_upd)
  );

  assign wr_a0 = (ins.wb == WB_A0) || (ins.wb == WB_BOTH);
  assign wr_a1 = (ins.wb == WB_A1) || (ins.wb == WB_BOTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a0_q    <= '0;
      a1_q    <= '0;
      carry_q <= 1'b0;
    end else begin
      if (wr_a0) a0_q <= res;
      if (wr_a1) a1_q <= res;
      if (c_upd) carry_q <= cout;
    end
  end

  assign pout       = tap;
  assign flag_carry = carry_q;
  assign zero_a0    = (a0_q == '0);
  assign zero_a1    = (a1_q == '0);
  assign eq_a01     = (a0_q == a1_q);

endmodule

// File: rtl/dp_accum8_chk.sv
module dp_accum8_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] pout,
  input logic [DW-1:0] a0_q,
  input logic [DW-1:0] a1_q,
  input logic          carry_q,
  input logic [1:0]    fn,
  input logic [1:0]    wb
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (a0_q == '0 && a1_q == '0 && !carry_q)); // R1

  AST_POUT_ACC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pout == a0_q) || (pout == a1_q)); // R4

  AST_NO_WB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wb == 2'd0) |=> ($stable(a0_q) && $stable(a1_q))); // R6

  AST_PASS_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == 2'd0) |=> $stable(carry_q)); // R7

endmodule

bind dp_accum8 dp_accum8_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pout    (pout),
  .a0_q    (a0_q),
  .a1_q    (a1_q),
  .carry_q (carry_q),
  .fn      (ins.fn),
  .wb      (ins.wb)
);

// File: tb/tb_dp_accum8.sv
`timescale 1ns/1ps
module tb_dp_accum8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_word = '0;
  logic       pin_en = 1'b1;
  logic [2:0] state = 3'd6;
  logic [7:0] pin = '0;
  logic [7:0] pout;
  logic       flag_carry, zero_a0, zero_a1, eq_a01;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  dp_accum8 dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_word(cfg_word), .pin_en(pin_en), .state(state), .pin(pin),
    .pout(pout), .flag_carry(flag_carry), .zero_a0(zero_a0),
    .zero_a1(zero_a1), .eq_a01(eq_a01)
  );

  // word = {fn[7:6], a_hi, use_pin, b_hi, wb[2:1], chain} (R3, R5, R6)
  function automatic logic [7:0] mk(input logic [1:0] fn, input logic ahi,
      input logic up, input logic bhi, input logic [1:0] wb, input logic ch);
    return {fn, ahi, up, bhi, wb, ch};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] a, input logic [7:0] w);
    cfg_we = 1'b1; cfg_addr = a; cfg_word = w;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // execute one instruction, return in the low phase after the edge
  task automatic run(input logic [2:0] s, input logic [7:0] p);
    state = s; pin = p;
    @(posedge clk); @(negedge clk);
  endtask

  // read an accumulator through a no-write slot (6 -> A0, 7 -> A1)
  task automatic peek(input logic [2:0] s, output logic [7:0] v);
    state = s; #0.5; v = pout;
  endtask

  // {sel, pin, expA0, expA1, expCarry}
  localparam logic [27:0] VEC [20] = '{
    {3'd1, 8'h12, 8'h00, 8'h12, 1'b0},  // R6 load A1 via pin
    {3'd0, 8'h34, 8'h34, 8'h12, 1'b0},  // R3 load A0 via pin
    {3'd2, 8'h00, 8'h46, 8'h12, 1'b0},  // R5 ADD no overflow
    {3'd0, 8'hF0, 8'hF0, 8'h12, 1'b0},
    {3'd2, 8'h00, 8'h02, 8'h12, 1'b1},  // R7 ADD overflow
    {3'd3, 8'h00, 8'hF0, 8'h12, 1'b0},  // R7 SUB borrow
    {3'd3, 8'h00, 8'hDE, 8'h12, 1'b1},  // R7 SUB no borrow
    {3'd1, 8'h01, 8'hDE, 8'h01, 1'b1},  // R7 PASS holds carry
    {3'd0, 8'h00, 8'h00, 8'h01, 1'b1},
    {3'd4, 8'hFB, 8'hFB, 8'h01, 1'b0},  // R9 0x0100 - 5 low byte
    {3'd5, 8'h00, 8'hFB, 8'h00, 1'b1},  // R9 R8 chained DEC -> 0x00FB
    {3'd4, 8'hFB, 8'hF6, 8'h00, 1'b1},
    {3'd5, 8'h00, 8'hF6, 8'h00, 1'b1},  // R9 no decrement -> 0x00F6
    {3'd4, 8'hFB, 8'hF1, 8'h00, 1'b1},
    {3'd0, 8'h02, 8'h02, 8'h00, 1'b1},
    {3'd4, 8'hFB, 8'hFD, 8'h00, 1'b0},
    {3'd5, 8'h00, 8'hFD, 8'hFF, 1'b0},  // R9 wrap -> 0xFFFD
    {3'd6, 8'h00, 8'hFD, 8'hFF, 1'b0},  // R11 nop
    {3'd1, 8'hFD, 8'hFD, 8'hFD, 1'b0},
    {3'd3, 8'h00, 8'h00, 8'hFD, 1'b1}   // R7 SUB equal operands
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    // program the store while in reset (R2)
    @(negedge clk);
    cfg(3'd0, mk(2'd0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0));
    cfg(3'd1, mk(2'd0, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0));
    cfg(3'd2, mk(2'd1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0));
    cfg(3'd3, mk(2'd2, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0));
    cfg(3'd4, mk(2'd1, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0));
    cfg(3'd5, mk(2'd3, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1));
    cfg(3'd6, mk(2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0));
    cfg(3'd7, mk(2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0));
    rst_n = 1'b1;

    // R1 reset state, R10 flags after reset
    peek(3'd6, v); chk("R1 A0 after reset", v, 8'h00);
    peek(3'd7, v); chk("R1 A1 after reset", v, 8'h00);
    chk("R1 carry after reset", {7'd0, flag_carry}, 8'h00);
    chk("R10 flags after reset", {5'd0, zero_a0, zero_a1, eq_a01}, 8'h07);

    // vector table: R5 R6 R7 R8 R9 R11
    for (int i = 0; i < 20; i++) begin
      run(VEC[i][27:25], VEC[i][24:17]);
      peek(3'd6, v); chk($sformatf("R6 vec%0d A0", i), v, VEC[i][16:9]);
      peek(3'd7, v); chk($sformatf("R6 vec%0d A1", i), v, VEC[i][8:1]);
      chk($sformatf("R7 vec%0d carry", i), {7'd0, flag_carry}, {7'd0, VEC[i][0]});
    end

    // R10: A0=00, A1=FD
    chk("R10 flags A0=0 A1=FD", {5'd0, zero_a0, zero_a1, eq_a01}, 8'h04);

    // R4: pin feeds the ALU but pout shows A0
    state = 3'd0; pin = 8'hAA; #0.5;
    chk("R4 pout not pin", pout, 8'h00);

    // R3: static enable low, slot 1 copies first-stage A0 into A1
    pin_en = 1'b0;
    run(3'd1, 8'h55);
    peek(3'd7, v); chk("R3 pin gated by static enable", v, 8'h00);
    chk("R10 eq flag", {7'd0, eq_a01}, 8'h01);
    pin_en = 1'b1;

    // R2: write outside reset is ignored
    run(3'd1, 8'h3C);
    cfg_we = 1'b1; cfg_addr = 3'd7; cfg_word = mk(2'd0, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0);
    run(3'd6, 8'h00);
    cfg_we = 1'b0;
    run(3'd7, 8'h77);
    peek(3'd7, v); chk("R2 store write outside reset", v, 8'h3C);

    // R1: async reset clears state, store survives
    state = 3'd7;
    rst_n = 1'b0; #0.5;
    chk("R1 A1 cleared by reset", pout, 8'h00);
    chk("R1 carry cleared by reset", {7'd0, flag_carry}, 8'h00);
    @(negedge clk);
    cfg(3'd5, mk(2'd3, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0)); // plain DEC on A1
    rst_n = 1'b1;

    run(3'd1, 8'h00);
    peek(3'd7, v); chk("R1 store kept over reset", v, 8'h00);
    run(3'd5, 8'h00);
    peek(3'd7, v); chk("R5 DEC wrap", v, 8'hFF);
    chk("R7 DEC borrow carry", {7'd0, flag_carry}, 8'h00);
    run(3'd5, 8'h00);
    peek(3'd7, v); chk("R5 DEC", v, 8'hFE);
    chk("R7 DEC carry", {7'd0, flag_carry}, 8'h01);
    run(3'd5, 8'h00);
    peek(3'd7, v); chk("R8 unchained DEC ignores carry", v, 8'hFD);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule